// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block produces one delayed pulse on an output pin for each qualifying edge on an external trigger input. The trigger is brought into the clock domain through a synchronizer chain. A qualifying edge clears an up-counter to zero and starts it. The counter advances once on each cycle in which the count-enable tick is high. The output enters its active level one clock after the count equals the start compare value. It leaves the active level one clock after the count equals the stop compare value.

When the counter passes its all-ones value it wraps to zero and stops there until the next qualifying edge. The wrap also ends any pulse still in progress. A qualifying edge that arrives during a pulse restarts the count from zero and drops the output at once. A configuration bit selects whether the active level is high or low. An enable bit gates the pin: when it is low the pin sits at the inactive level, while the internal pulse keeps running.

The counter width and the synchronizer depth are parameters. The counter value and a running flag are brought out for observation.

Top module: `ospt_oneshot_timer`

## Requirements
- R1: After reset the count is zero, the running flag is low and the pin shows the inactive level (low when `act_high_i` is 1, high when it is 0).
- R2: `edge_sel_i` picks the qualifying trigger edge: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. All other edges are ignored. A qualifying change on `trig_i` sets the count to zero and raises the running flag at the third rising clock edge after the change.
- R3: While running, the count rises by exactly one at each clock edge where `tick_i` was high, and holds its value when `tick_i` is low.
- R4: The output becomes active one clock after the count equals `cmp_on_i` while running. For a start value below the stop value, the output is active exactly for counts start+1 through stop.
- R5: The output returns to inactive one clock after the count equals `cmp_off_i` while running.
- R6: When `cmp_on_i` equals `cmp_off_i`, the output never becomes active.
- R7: With `act_high_i` = 1 the active level is high; with 0 it is low. The inactive level is always the opposite of the active level.
- R8: With `out_en_i` low the pin shows the inactive level, while the internal pulse state still runs. Raising `out_en_i` during a pulse shows the active level in the same cycle.
- R9: At a counted edge from the all-ones value, the count becomes zero, the running flag drops and the output goes inactive. The counter then holds zero until the next qualifying edge. For a start value above the stop value, the output is active from count start+1 up to this wrap.
- R10: A qualifying edge during a pulse restarts the count from zero and forces the output inactive.
- R11: A match with `cmp_on_i` does not disturb the count, which keeps rising past the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable tick |
| trig_i | input | 1 | External trigger pin, asynchronous |
| edge_sel_i | input | 2 | Qualifying edge select |
| cmp_on_i | input | CNT_W | Start compare value |
| cmp_off_i | input | CNT_W | Stop compare value |
| act_high_i | input | 1 | 1: active level high, 0: active level low |
| out_en_i | input | 1 | Pin drive enable |
| pulse_o | output | 1 | Pulse pin |
| count_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Counter is running |

## Verification
The bench uses a 5-bit counter and sweeps every pair of start and stop values, with the polarity alternating. This shows the three window shapes apart: start below stop gives a window that closes on the stop match, start above stop gives a window that closes on the wrap, and equal values give no window. It also covers the all-ones and zero extremes. Directed runs then try a sparse tick pattern, which shows counting on ticks apart from counting on clocks. They try each edge-select code with both trigger directions, which shows qualifying edges apart from ignored ones. A retrigger in mid-pulse checks the restart, and a disabled pin with a pulse running inside checks the enable gating.

// File: rtl/ospt_pkg.sv
package ospt_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   function automatic logic edge_hit(input edge_sel_e sel, input logic cur, input logic prev);
      logic rise;
      logic fall;
      rise = cur & ~prev;
      fall = ~cur & prev;
      unique case (sel)
         EDGE_RISE: edge_hit = rise;
         EDGE_FALL: edge_hit = fall;
         EDGE_BOTH: edge_hit = rise | fall;
         default:   edge_hit = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ospt_trig_detect.sv
module ospt_trig_detect
   import ospt_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trig_i,
   input  edge_sel_e sel_i,
   output logic      fire_o
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [LAST:0] chain_q;
   logic          prev_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= trig_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[LAST];
   end

   always_comb fire_o = edge_hit(sel_i, chain_q[LAST], prev_q);

endmodule

// File: rtl/ospt_counter.sv
module ospt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             busy_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             step;

   always_comb begin
      step   = busy_q & tick_i & ~fire_i;
      wrap_o = step & (cnt_q == CNT_MAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (fire_i) begin
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (wrap_o) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (step) begin
         cnt_q  <= cnt_q + CNT_ONE;
      end
   end

   assign cnt_o  = cnt_q;
   assign busy_o = busy_q;

endmodule

// File: rtl/ospt_out_stage.sv
module ospt_out_stage #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic             wrap_i,
   input  logic             busy_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_on_i,
   input  logic [CNT_W-1:0] cmp_off_i,
   input  logic             act_high_i,
   input  logic             out_en_i,
   output logic             act_o,
   output logic             pin_o
);
   logic act_q;
   logic hit_on;
   logic hit_off;
   logic same_cmp;

   always_comb begin
      same_cmp = (cmp_on_i == cmp_off_i);
      hit_on   = busy_i & (cnt_i == cmp_on_i) & ~same_cmp;
      hit_off  = busy_i & (cnt_i == cmp_off_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                act_q <= 1'b0;
      else if (fire_i || wrap_i) act_q <= 1'b0;
      else if (hit_off)          act_q <= 1'b0;
      else if (hit_on)           act_q <= 1'b1;
   end

   always_comb pin_o = (out_en_i & act_q) ? act_high_i : ~act_high_i;
   assign act_o = act_q;

endmodule

// File: rtl/ospt_oneshot_timer.sv
module ospt_oneshot_timer
   import ospt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             trig_i,
   input  logic [1:0]       edge_sel_i,
   input  logic [CNT_W-1:0] cmp_on_i,
   input  logic [CNT_W-1:0] cmp_off_i,
   input  logic             act_high_i,
   input  logic             out_en_i,
   output logic             pulse_o,
   output logic [CNT_W-1:0] count_o,
   output logic             running_o
);
   initial begin
      if (CNT_W < 2 || CNT_W > 32) $fatal(1, "CNT_W must lie in 2..32");
      if (SYNC_STAGES < 2)         $fatal(1, "SYNC_STAGES must be at least 2");
   end

   edge_sel_e        sel;
   logic             fire;
   logic             wrap;
   logic             busy;
   logic             act;
   logic [CNT_W-1:0] cnt;

   assign sel = edge_sel_e'(edge_sel_i);

   ospt_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .trig_i(trig_i),
      .sel_i (sel),
      .fire_o(fire)
   );

   ospt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .fire_i(fire),
      .tick_i(tick_i),
      .cnt_o (cnt),
      .busy_o(busy),
      .wrap_o(wrap)
   );

   ospt_out_stage #(.CNT_W(CNT_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire),
      .wrap_i    (wrap),
      .busy_i    (busy),
      .cnt_i     (cnt),
      .cmp_on_i  (cmp_on_i),
      .cmp_off_i (cmp_off_i),
      .act_high_i(act_high_i),
      .out_en_i  (out_en_i),
      .act_o     (act),
      .pin_o     (pulse_o)
   );

   assign count_o   = cnt;
   assign running_o = busy;

endmodule

// File: rtl/ospt_oneshot_sva.sv
module ospt_oneshot_sva #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             fire,
   input logic             busy,
   input logic             act,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cmp_on,
   input logic [CNT_W-1:0] cmp_off,
   input logic             act_high,
   input logic             out_en,
   input logic             pulse
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   assert_fire_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (count == '0) && busy);

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick && !fire && count != CMAX) |=> count == $past(count) + 1'b1);

   assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !fire) |=> $stable(count));

   assert_rise_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act) |-> ($past(count) == $past(cmp_on)) && $past(busy));

   assert_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act) |-> ($past(fire) || ($past(count) == $past(cmp_off))
                      || ($past(count) == CMAX && $past(tick))));

   assert_equal_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act) |-> $past(cmp_on) != $past(cmp_off));

   assert_pin_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> pulse == !act_high);

   assert_wrap_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick && !fire && count == CMAX) |=> (count == '0) && !busy && !act);

   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> count == '0);

   assert_retrig_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !act);

endmodule

bind ospt_oneshot_timer ospt_oneshot_sva #(.CNT_W(CNT_W)) u_sva (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick_i),
   .fire    (fire),
   .busy    (busy),
   .act     (act),
   .count   (count_o),
   .cmp_on  (cmp_on_i),
   .cmp_off (cmp_off_i),
   .act_high(act_high_i),
   .out_en  (out_en_i),
   .pulse   (pulse_o)
);

// File: tb/tb_ospt_oneshot_timer.sv
`timescale 1ns/1ps
module tb_ospt_oneshot_timer;
   localparam int W    = 5;
   localparam int CMAX = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_i = 1'b1;
   logic         trig_i = 1'b0;
   logic [1:0]   edge_sel_i = 2'b01;
   logic [W-1:0] cmp_on_i = '0;
   logic [W-1:0] cmp_off_i = '0;
   logic         act_high_i = 1'b1;
   logic         out_en_i = 1'b1;
   logic         pulse_o;
   logic [W-1:0] count_o;
   logic         running_o;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ospt_oneshot_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .trig_i(trig_i),
      .edge_sel_i(edge_sel_i), .cmp_on_i(cmp_on_i), .cmp_off_i(cmp_off_i),
      .act_high_i(act_high_i), .out_en_i(out_en_i),
      .pulse_o(pulse_o), .count_o(count_o), .running_o(running_o)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int pin_exp(input bit active, input bit hi, input bit en);
      return (active && en) ? int'(hi) : int'(!hi);
   endfunction

   function automatic bit in_window(input int a, input int b, input int j);
      if (a == b || j > CMAX) return 1'b0;
      if (a < b) return (j > a) && (j <= b);
      return j > a;
   endfunction

   initial begin
      steps(3);
      chk("R1 count", count_o, 0);
      chk("R1 running", running_o, 0);
      chk("R1 pin high-active", pulse_o, 0);
      act_high_i = 1'b0; #1;
      chk("R1 pin low-active", pulse_o, 1);
      act_high_i = 1'b1;
      rst_n = 1'b1;
      steps(2);

      // R4 R5 R6 R7 R9 R11: every start/stop pair, rising edges
      for (int a = 0; a <= CMAX; a++) begin
         for (int b = 0; b <= CMAX; b++) begin
            bit hi;
            hi = ((a + b) % 2) == 0;
            cmp_on_i = W'(a); cmp_off_i = W'(b); act_high_i = hi;
            trig_i = 1'b1;
            steps(3);
            for (int j = 0; j <= CMAX + 1; j++) begin
               chk("R3 R11 sweep count", count_o, (j <= CMAX) ? j : 0);
               chk("R9 sweep running", running_o, (j <= CMAX) ? 1 : 0);
               chk("R4 R5 R6 R7 R9 sweep pin", pulse_o, pin_exp(in_window(a, b, j), hi, 1'b1));
               if (j <= CMAX) step();
            end
            trig_i = 1'b0;
            steps(4);
            chk("R2 falling ignored / R9 hold", running_o, 0);
            chk("R9 holds zero", count_o, 0);
         end
      end

      // R3: sparse tick
      act_high_i = 1'b1; cmp_on_i = 5'd30; cmp_off_i = 5'd31;
      trig_i = 1'b1; steps(3);
      chk("R3 start", count_o, 0);
      begin
         int e;
         e = 0;
         for (int k = 0; k < 24; k++) begin
            tick_i = (k % 3) == 0;
            step();
            if (tick_i) e++;
            chk("R3 tick gating", count_o, e);
         end
      end
      tick_i = 1'b1;
      trig_i = 1'b0; steps(40);
      chk("R9 idle after sparse", running_o, 0);

      // R8: disabled pin with running pulse
      cmp_on_i = 5'd1; cmp_off_i = 5'd6; out_en_i = 1'b0;
      trig_i = 1'b1; steps(3);
      for (int j = 0; j < 4; j++) begin
         chk("R8 pin gated", pulse_o, 0);
         step();
      end
      out_en_i = 1'b1; #1;
      chk("R8 internal pulse live", pulse_o, 1);
      trig_i = 1'b0; steps(40);

      // R2 R10: both edges, retrigger mid-pulse
      edge_sel_i = 2'b11; cmp_on_i = 5'd2; cmp_off_i = 5'd20;
      trig_i = 1'b1; steps(3);
      steps(8);
      chk("R10 pre count", count_o, 8);
      chk("R10 pre pin active", pulse_o, 1);
      trig_i = 1'b0;
      steps(2);
      chk("R2 sync delay", count_o, 10);
      step();
      chk("R10 restart count", count_o, 0);
      chk("R10 pin inactive", pulse_o, 0);
      chk("R2 both-edge running", running_o, 1);
      steps(40);

      // R2: falling only
      edge_sel_i = 2'b10;
      trig_i = 1'b1; steps(5);
      chk("R2 rise ignored under falling select", running_o, 0);
      trig_i = 1'b0; steps(3);
      chk("R2 falling start", running_o, 1);
      steps(5);
      chk("R2 falling count", count_o, 5);
      steps(40);

      // R2: no edge selected
      edge_sel_i = 2'b00;
      trig_i = 1'b1; steps(5);
      trig_i = 1'b0; steps(5);
      chk("R2 none selected", running_o, 0);
      chk("R2 none count", count_o, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule